// File: doc/BRIEF.md
# Disk DMA Transfer Sequencer

This block steers a transfer between a storage device and a DMA channel. The transfer is split into chunks. A start command loads the transfer: the command type, the drive kind, the first sector (or optical LBA), the sector count and the optical packet size. The block sets the remaining byte count, clears the running byte index and marks the transfer active.

Each time the DMA channel presents a descriptor, the block decides what to do with it. It can issue one chunk request (read, write, trim or packet copy) at the right device byte offset. It can end only the descriptor. It can finish the whole transfer with a status byte and an interrupt. Or it can hold the descriptor until the next start. After a chunk has been issued, the block waits for that chunk's completion and its error flag, then decides again.

Top module: `disk_dma_seq`

## Requirements
- R1: After reset `req_o`, `dma_end_o` and `irq_o` are 0 and `status_o` is 8'h00.
- R2: On a disk, an accepted start sets the remaining count to `count_i`*512 and the index to 0. A descriptor of nonzero length then yields one chunk with `req_off_o` = sector*512 + index and `req_len_o` = descriptor length. `req_kind_o` equals the command code: 2'b00 read, 2'b01 write, 2'b10 trim. The chunk length is subtracted from the remaining count and added to the index.
- R3: A start with command 2'b11 on a disk is ignored. The block stays inactive, so a descriptor presented afterwards waits.
- R4: A descriptor presented while the block is inactive produces no chunk and no `dma_end_o`. It is kept, and the next accepted start processes it.
- R5: When a chunk completes without error and bytes remain, only `dma_end_o` pulses. `status_o` and `irq_o` do not change. The next descriptor continues at the advanced index.
- R6: When a chunk completes (or a descriptor arrives) with the remaining count at or below zero, `status_o` becomes 8'h50, `irq_o` goes to 1, `dma_end_o` pulses and the block becomes inactive.
- R7: On an optical drive the remaining count is `pkt_size_i`. The offset is LBA*2048 + index, and the kind is always read (2'b00) whatever `cmd_i` holds.
- R8: On an optical drive with an all-ones LBA, a descriptor yields one chunk of kind 2'b11, offset 0 and length min(remaining, descriptor length). In the same cycle the block ends the transfer with 8'h50, `irq_o` = 1 and `dma_end_o`.
- R9: A completion with `err_i` = 1 sets `status_o` to 8'h51, sets `irq_o`, pulses `dma_end_o` and leaves the block inactive.
- R10: An accepted start clears `irq_o`.
- R11: A zero-length descriptor while bytes remain pulses `dma_end_o` only, with no chunk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start command (one-cycle pulse) |
| cmd_i | input | 2 | Command type: 00 read, 01 write, 10 trim, 11 none |
| optical_i | input | 1 | Drive is optical |
| sector_i | input | SECT_W | First disk sector or optical LBA |
| count_i | input | CNT_W | Disk sector count |
| pkt_size_i | input | PKT_W | Optical packet transfer size in bytes |
| kick_i | input | 1 | DMA channel presents a descriptor |
| desc_len_i | input | LEN_W | Descriptor length in bytes |
| done_i | input | 1 | Outstanding chunk completed |
| err_i | input | 1 | Completion reports an error |
| req_o | output | 1 | Chunk request pulse |
| req_kind_o | output | 2 | Chunk kind: 00 read, 01 write, 10 trim, 11 packet copy |
| req_off_o | output | SECT_W+12 | Device byte offset of the chunk |
| req_len_o | output | LEN_W | Chunk length in bytes |
| status_o | output | 8 | Device status byte |
| irq_o | output | 1 | Device interrupt (level) |
| dma_end_o | output | 1 | Descriptor end pulse |

## Verification
The bench builds the block with SECT_W=24, CNT_W=8, PKT_W=17 and LEN_W=16. With these values an all-ones LBA is 24'hFFFFFF, so the packet path can be reached. A 2048-byte optical chunk followed by a 4096-byte descriptor drives the remaining count below zero. This exercises the signed end test, not only the exact-zero case. The narrow count keeps disk transfers to a few chunks, so the bench reaches the multi-descriptor continuation, the error path and the zero-length descriptor within a few hundred cycles.

// File: rtl/disk_dma_seq_pkg.sv
package disk_dma_seq_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_EVAL = 2'd1,
    S_WAIT = 2'd2
  } seq_state_e;

  localparam logic [1:0] CMD_NONE = 2'b11;
  localparam logic [1:0] KIND_RD  = 2'b00;
  localparam logic [1:0] KIND_PKT = 2'b11;

  localparam logic [7:0] STAT_DONE = 8'h50;
  localparam logic [7:0] STAT_ERR  = 8'h51;
endpackage

// File: rtl/disk_dma_seq_track.sv
module disk_dma_seq_track #(
  parameter int ACC_W = 19,
  parameter int LEN_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [ACC_W-1:0]        load_size_i,
  input  logic                    adv_i,
  input  logic [LEN_W-1:0]        adv_len_i,
  output logic signed [ACC_W-1:0] size_o,
  output logic [ACC_W-1:0]        idx_o,
  output logic                    empty_o
);
  logic [ACC_W-1:0] len_ext;
  assign len_ext = ACC_W'(adv_len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_o <= '0;
      idx_o  <= '0;
    end else if (load_i) begin
      size_o <= $signed(load_size_i);
      idx_o  <= '0;
    end else if (adv_i) begin
      size_o <= size_o - $signed(len_ext);
      idx_o  <= idx_o + len_ext;
    end
  end

  // remaining count at or below zero ends the device transfer
  assign empty_o = size_o[ACC_W-1] || (size_o == '0);

  AST_LOAD_CLEARS_IDX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> idx_o == '0); // R2
  AST_ADV_SHRINKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && adv_len_i != '0) |=> size_o < $past(size_o)); // R5
endmodule

// File: rtl/disk_dma_seq_offset.sv
module disk_dma_seq_offset #(
  parameter int SECT_W = 24,
  parameter int IDX_W  = 19,
  parameter int OFF_W  = 36
) (
  input  logic [SECT_W-1:0] sector_i,
  input  logic              optical_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [OFF_W-1:0]  off_o
);
  localparam int DISK_SH = 9;
  localparam int OPT_SH  = 11;

  logic [OFF_W-1:0] base_disk, base_opt;

  assign base_disk = OFF_W'(sector_i) << DISK_SH;
  assign base_opt  = OFF_W'(sector_i) << OPT_SH;
  assign off_o     = (optical_i ? base_opt : base_disk) + OFF_W'(idx_i);
endmodule

// File: rtl/disk_dma_seq.sv
module disk_dma_seq
  import disk_dma_seq_pkg::*;
#(
  parameter int SECT_W = 24,
  parameter int CNT_W  = 8,
  parameter int PKT_W  = 17,
  parameter int LEN_W  = 16,
  parameter int OFF_W  = SECT_W + 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        cmd_i,
  input  logic              optical_i,
  input  logic [SECT_W-1:0] sector_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [PKT_W-1:0]  pkt_size_i,
  input  logic              kick_i,
  input  logic [LEN_W-1:0]  desc_len_i,
  input  logic              done_i,
  input  logic              err_i,
  output logic              req_o,
  output logic [1:0]        req_kind_o,
  output logic [OFF_W-1:0]  req_off_o,
  output logic [LEN_W-1:0]  req_len_o,
  output logic [7:0]        status_o,
  output logic              irq_o,
  output logic              dma_end_o
);
  localparam int SIZE_W = (CNT_W + 9 > PKT_W) ? CNT_W + 9 : PKT_W;
  localparam int ACC_W  = ((SIZE_W > LEN_W) ? SIZE_W : LEN_W) + 2;

  seq_state_e        state_q;
  logic              active_q, pend_q, err_q, optical_q;
  logic [1:0]        cmd_q;
  logic [SECT_W-1:0] sector_q;
  logic [LEN_W-1:0]  desc_len_q;

  logic                    req_q, dma_end_q, irq_q;
  logic [1:0]              req_kind_q;
  logic [OFF_W-1:0]        req_off_q;
  logic [LEN_W-1:0]        req_len_q;
  logic [7:0]              status_q;

  logic                    start_ok, load, issue, null_lba, empty;
  logic [ACC_W-1:0]        load_size, idx;
  logic signed [ACC_W-1:0] size, desc_s;
  logic [LEN_W-1:0]        pkt_len;
  logic [OFF_W-1:0]        chunk_off;

  always_comb begin
    start_ok  = optical_i || (cmd_i != CMD_NONE);
    load      = (state_q == S_IDLE) && start_i && start_ok;
    load_size = optical_i ? ACC_W'(pkt_size_i) : ACC_W'({count_i, 9'b0});
    null_lba  = &sector_q;
    issue     = (state_q == S_EVAL) && !err_q && active_q && !empty &&
                (desc_len_q != '0) && !(optical_q && null_lba);
    desc_s    = $signed(ACC_W'(desc_len_q));
    pkt_len   = (size < desc_s) ? size[LEN_W-1:0] : desc_len_q;
  end

  disk_dma_seq_track #(.ACC_W(ACC_W), .LEN_W(LEN_W)) track_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load),
    .load_size_i (load_size),
    .adv_i       (issue),
    .adv_len_i   (desc_len_q),
    .size_o      (size),
    .idx_o       (idx),
    .empty_o     (empty)
  );

  disk_dma_seq_offset #(.SECT_W(SECT_W), .IDX_W(ACC_W), .OFF_W(OFF_W)) offset_i (
    .sector_i  (sector_q),
    .optical_i (optical_q),
    .idx_i     (idx),
    .off_o     (chunk_off)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      active_q   <= 1'b0;
      pend_q     <= 1'b0;
      err_q      <= 1'b0;
      optical_q  <= 1'b0;
      cmd_q      <= '0;
      sector_q   <= '0;
      desc_len_q <= '0;
      req_q      <= 1'b0;
      req_kind_q <= '0;
      req_off_q  <= '0;
      req_len_q  <= '0;
      status_q   <= '0;
      irq_q      <= 1'b0;
      dma_end_q  <= 1'b0;
    end else begin
      req_q     <= 1'b0;
      dma_end_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (load) begin
            cmd_q     <= cmd_i;
            optical_q <= optical_i;
            sector_q  <= sector_i;
            active_q  <= 1'b1;
            irq_q     <= 1'b0;
            err_q     <= 1'b0;
            if (pend_q) begin
              pend_q  <= 1'b0;
              state_q <= S_EVAL;
            end
          end else if (kick_i && !start_i) begin
            desc_len_q <= desc_len_i;
            err_q      <= 1'b0;
            state_q    <= S_EVAL;
          end
        end
        S_EVAL: begin
          state_q <= S_IDLE;
          if (err_q) begin
            status_q  <= STAT_ERR;
            irq_q     <= 1'b1;
            dma_end_q <= 1'b1;
            active_q  <= 1'b0;
          end else if (!active_q) begin
            pend_q <= 1'b1;  // hold descriptor until restarted
          end else if (empty) begin
            status_q  <= STAT_DONE;
            irq_q     <= 1'b1;
            dma_end_q <= 1'b1;
            active_q  <= 1'b0;
          end else if (desc_len_q == '0) begin
            dma_end_q <= 1'b1;
          end else if (optical_q && null_lba) begin
            req_q      <= 1'b1;
            req_kind_q <= KIND_PKT;
            req_off_q  <= '0;
            req_len_q  <= pkt_len;
            status_q   <= STAT_DONE;
            irq_q      <= 1'b1;
            dma_end_q  <= 1'b1;
            active_q   <= 1'b0;
          end else begin
            req_q      <= 1'b1;
            req_kind_q <= optical_q ? KIND_RD : cmd_q;
            req_off_q  <= chunk_off;
            req_len_q  <= desc_len_q;
            desc_len_q <= '0;
            state_q    <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (done_i) begin
            err_q   <= err_i;
            state_q <= S_EVAL;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_o      = req_q;
  assign req_kind_o = req_kind_q;
  assign req_off_o  = req_off_q;
  assign req_len_o  = req_len_q;
  assign status_o   = status_q;
  assign irq_o      = irq_q;
  assign dma_end_o  = dma_end_q;

  AST_REQ_FROM_EVAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(state_q == S_EVAL)); // R2
  AST_NO_REQ_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(active_q)); // R4
  AST_BLOCK_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && req_kind_q != KIND_PKT) |-> (state_q == S_WAIT && !dma_end_q)); // R5
  AST_IRQ_WITH_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> (dma_end_q && !active_q)); // R6
  AST_IRQ_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> (status_q == STAT_DONE || status_q == STAT_ERR)); // R9
  AST_PKT_FINISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_q && req_kind_q == KIND_PKT) |-> (dma_end_q && irq_q)); // R8
endmodule

// File: tb/disk_dma_seq_tb_top.sv
module disk_dma_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SECT_W = 24;
  localparam int CNT_W  = 8;
  localparam int PKT_W  = 17;
  localparam int LEN_W  = 16;
  localparam int OFF_W  = SECT_W + 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, optical = 1'b0, kick = 1'b0, done = 1'b0, err = 1'b0;
  logic [1:0]        cmd = '0;
  logic [SECT_W-1:0] sector = '0;
  logic [CNT_W-1:0]  count = '0;
  logic [PKT_W-1:0]  pkt = '0;
  logic [LEN_W-1:0]  dlen = '0;

  logic              req, irq, dma_end;
  logic [1:0]        req_kind;
  logic [OFF_W-1:0]  req_off;
  logic [LEN_W-1:0]  req_len;
  logic [7:0]        status;

  always #(CLK_PERIOD/2) clk = ~clk;

  disk_dma_seq #(.SECT_W(SECT_W), .CNT_W(CNT_W), .PKT_W(PKT_W), .LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .optical_i(optical),
    .sector_i(sector), .count_i(count), .pkt_size_i(pkt), .kick_i(kick),
    .desc_len_i(dlen), .done_i(done), .err_i(err), .req_o(req), .req_kind_o(req_kind),
    .req_off_o(req_off), .req_len_o(req_len), .status_o(status), .irq_o(irq),
    .dma_end_o(dma_end)
  );

  typedef struct {
    logic [1:0]       kind;
    logic [OFF_W-1:0] off;
    logic [LEN_W-1:0] len;
    string            tag;
  } exp_req_t;

  typedef struct {
    logic [7:0] st;
    logic       irq;
    string      tag;
  } exp_end_t;

  exp_req_t req_q[$];
  exp_end_t end_q[$];
  int checks = 0, failures = 0;
  int req_seen = 0, end_seen = 0;
  string cur_tag = "R1";
  bit finished = 1'b0;

  // monitor: pops the scoreboard on each pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (req) begin
        req_seen++;
        checks++;
        if (req_q.size() == 0) begin
          failures++;
          $display("FAIL %s unexpected chunk: got kind=%0d off=%0d len=%0d expected none",
                   cur_tag, req_kind, req_off, req_len);
        end else begin
          exp_req_t e;
          e = req_q.pop_front();
          if (req_kind !== e.kind || req_off !== e.off || req_len !== e.len) begin
            failures++;
            $display("FAIL %s chunk: got kind=%0d off=%0d len=%0d expected kind=%0d off=%0d len=%0d",
                     e.tag, req_kind, req_off, req_len, e.kind, e.off, e.len);
          end
        end
      end
      if (dma_end) begin
        end_seen++;
        checks++;
        if (end_q.size() == 0) begin
          failures++;
          $display("FAIL %s unexpected end: got status=%h irq=%0d expected none",
                   cur_tag, status, irq);
        end else begin
          exp_end_t e;
          e = end_q.pop_front();
          if (status !== e.st || irq !== e.irq) begin
            failures++;
            $display("FAIL %s end: got status=%h irq=%0d expected status=%h irq=%0d",
                     e.tag, status, irq, e.st, e.irq);
          end
        end
      end
    end
  end

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_req(input logic [1:0] k, input longint off, input int len, input string tag);
    exp_req_t e;
    e.kind = k; e.off = OFF_W'(off); e.len = LEN_W'(len); e.tag = tag;
    req_q.push_back(e);
  endtask

  task automatic push_end(input logic [7:0] st, input logic i, input string tag);
    exp_end_t e;
    e.st = st; e.irq = i; e.tag = tag;
    end_q.push_back(e);
  endtask

  task automatic do_start(input logic [1:0] c, input logic opt, input longint sec,
                          input int cnt, input int psz);
    @(negedge clk);
    start = 1'b1; cmd = c; optical = opt; sector = SECT_W'(sec);
    count = CNT_W'(cnt); pkt = PKT_W'(psz);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic do_kick(input int len);
    @(negedge clk);
    kick = 1'b1; dlen = LEN_W'(len);
    @(negedge clk);
    kick = 1'b0;
    idle(4);
  endtask

  task automatic do_done(input logic e);
    @(negedge clk);
    done = 1'b1; err = e;
    @(negedge clk);
    done = 1'b0; err = 1'b0;
    idle(4);
  endtask

  task automatic quiet_check(input string tag, input int r0, input int e0);
    check({tag, " no chunk"}, 64'(req_seen), 64'(r0));
    check({tag, " no end"}, 64'(end_seen), 64'(e0));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r0, e0;
    idle(3);
    // R1 reset state
    check("R1 req", 64'(req), 64'd0);
    check("R1 dma_end", 64'(dma_end), 64'd0);
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 status", 64'(status), 64'h00);
    rst_n = 1'b1;
    idle(2);

    // R4 descriptor before any start waits
    cur_tag = "R4";
    r0 = req_seen; e0 = end_seen;
    do_kick(512);
    quiet_check("R4", r0, e0);

    // R3 disk start with command 11 is ignored; descriptor still waits
    cur_tag = "R3";
    do_start(2'b11, 1'b0, 9, 3, 0);
    idle(4);
    quiet_check("R3", r0, e0);

    // R4 pending descriptor taken up by the next accepted start
    cur_tag = "R4";
    push_req(2'b00, 5*512 + 0, 512, "R4");
    do_start(2'b00, 1'b0, 5, 2, 0);
    idle(4);
    push_end(8'h00, 1'b0, "R5");
    cur_tag = "R5";
    do_done(1'b0);
    push_req(2'b00, 5*512 + 512, 512, "R5");
    do_kick(512);
    push_end(8'h50, 1'b1, "R6");
    cur_tag = "R6";
    do_done(1'b0);
    check("R6 irq level held", 64'(irq), 64'd1);

    // R10 start clears irq; R2 write chunk; R9 error
    cur_tag = "R10";
    do_start(2'b01, 1'b0, 10, 1, 0);
    check("R10 irq cleared", 64'(irq), 64'd0);
    cur_tag = "R2";
    push_req(2'b01, 10*512, 512, "R2");
    do_kick(512);
    push_end(8'h51, 1'b1, "R9");
    cur_tag = "R9";
    do_done(1'b1);
    r0 = req_seen; e0 = end_seen;
    do_kick(512);
    quiet_check("R9 inactive after error", r0, e0);
    cur_tag = "R2";
    push_req(2'b10, 0, 512, "R2");
    do_start(2'b10, 1'b0, 0, 1, 0);
    idle(4);
    push_end(8'h50, 1'b1, "R6");
    do_done(1'b0);

    // R11 zero-length descriptor while data remains
    cur_tag = "R11";
    do_start(2'b00, 1'b0, 1, 1, 0);
    push_end(8'h50, 1'b0, "R11");
    r0 = req_seen;
    do_kick(0);
    check("R11 no chunk", 64'(req_seen), 64'(r0));
    push_req(2'b00, 1*512, 512, "R11");
    do_kick(512);
    push_end(8'h50, 1'b1, "R6");
    do_done(1'b0);

    // R7 optical: 2048-byte blocks, kind read despite write command
    cur_tag = "R7";
    do_start(2'b01, 1'b1, 3, 0, 4096);
    push_req(2'b00, 3*2048, 2048, "R7");
    do_kick(2048);
    push_end(8'h50, 1'b0, "R5");
    do_done(1'b0);
    push_req(2'b00, 3*2048 + 2048, 4096, "R7");
    do_kick(4096);
    push_end(8'h50, 1'b1, "R6 overshoot");
    do_done(1'b0);

    // R8 null LBA packet copies min(size, desc)
    cur_tag = "R8";
    do_start(2'b00, 1'b1, 24'hFFFFFF, 0, 100);
    push_req(2'b11, 0, 100, "R8 size smaller");
    push_end(8'h50, 1'b1, "R8");
    do_kick(512);
    do_start(2'b00, 1'b1, 24'hFFFFFF, 0, 1000);
    push_req(2'b11, 0, 300, "R8 desc smaller");
    push_end(8'h50, 1'b1, "R8");
    do_kick(300);

    // R9 error on first chunk of a longer transfer
    cur_tag = "R9";
    do_start(2'b00, 1'b0, 7, 4, 0);
    push_req(2'b00, 7*512, 1024, "R9");
    do_kick(1024);
    push_end(8'h51, 1'b1, "R9");
    do_done(1'b1);

    idle(4);
    check("R2 all expected chunks seen", 64'(req_q.size()), 64'd0);
    check("R6 all expected ends seen", 64'(end_q.size()), 64'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule